// File: doc/BRIEF.md
# Two-Wire Serial Memory Bus Front End

This block is the bus-facing half of a serial memory device on a two-wire bus. It receives the raw clock and data lines and filters out short glitches on each. It recognises bus start and stop conditions and assembles each 8-bit word, most significant bit first. After every accepted word it pulls the data line low to acknowledge it. Each complete word is handed to the address and array logic behind it with a one-cycle strobe.

The first word after a start is the control word, and its lowest bit selects the direction: 1 for read, 0 for write. A stop that closes a write sequence carrying at least one data word launches an internal write cycle of fixed length. The busy flag is high for that whole cycle, and bus traffic during it is neither acknowledged nor passed on. A standby flag is set at reset and cleared by a start. It is set again at a stop, or at the end of the write cycle when the stop arrived while that cycle was running.

The data output is an open-drain pull-down enable: when it is high, the pad drives the line low. The wired line, as seen on the pad, must be fed back to the data input.

Top module: `twi_mem_front`

## Requirements
- R1: After reset, standby is 1 and busy, sda_pull and rx_valid are 0.
- R2: A falling data edge while the clock is high gives one start_pulse and clears standby unless busy is 1.
- R3: A rising data edge while the clock is high gives one stop_pulse. Data changes while the clock is low are never taken as start or stop.
- R4: A level on either line that lasts fewer than FILT_CYCLES system clocks is ignored.
- R5: Data is sampled on each rising clock edge. After the eighth bit, rx_byte holds the word with the first bit in bit 7, and rx_valid is high for exactly one cycle.
- R6: For an accepted word, sda_pull rises at the clock fall that follows the eighth bit and falls at the clock fall that follows the ninth. It stays 0 while the eighth bit is high.
- R7: If the control word has bit 0 = 1 (read), later words are neither strobed nor acknowledged. A stop then sets standby at once, without busy.
- R8: A stop that follows a control word with bit 0 = 0 and at least one complete data word raises busy for exactly WR_CYCLES clocks. Standby is 0 during that time and 1 when it ends, provided the bus is idle. Busy and standby are never both 1.
- R9: A stop after a write control word with no complete data word leaves busy at 0 and sets standby.
- R10: While busy, words are not strobed and not acknowledged, and standby stays 0. Start and stop pulses are still reported.
- R11: A start that arrives partway through a word discards the partial word and restarts bit counting. The next full word is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired value) |
| rx_byte | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| start_pulse | output | 1 | One-cycle pulse per start condition |
| stop_pulse | output | 1 | One-cycle pulse per stop condition |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Low-power idle state |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |

## Verification
The bench builds the block with FILT_CYCLES = 3 and WR_CYCLES = 2000, and runs each bus bit over 40 system clocks. The short timer lets a whole write cycle, including a second transaction placed inside it, run to completion, so its exact length can be measured. The small filter depth makes a glitch one clock shorter than the threshold cheap to stage, and still leaves each bus phase far longer than the filter and synchroniser latency.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int WORD_BITS = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WDATA,
        PH_READ
    } rx_phase_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_t;

    function automatic int ctr_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/twi_glitch_filt.sv
module twi_glitch_filt
    import twi_pkg::*;
#(
    parameter int FILT_CYCLES = 5,
    parameter bit IDLE_LEVEL  = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    output line_t line
);
    localparam int CW = ctr_w(FILT_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES - 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;
    logic          q, rise_r, fall_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= IDLE_LEVEL;
            s2     <= IDLE_LEVEL;
            cnt    <= '0;
            q      <= IDLE_LEVEL;
            rise_r <= 1'b0;
            fall_r <= 1'b0;
        end else begin
            s1     <= raw;
            s2     <= s1;
            rise_r <= 1'b0;
            fall_r <= 1'b0;
            if (s2 == q) begin
                cnt <= '0;
            end else if (cnt == LIMIT) begin
                cnt    <= '0;
                q      <= s2;
                rise_r <= s2;
                fall_r <= ~s2;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line.level = q;
    assign line.rise  = rise_r;
    assign line.fall  = fall_r;

endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond
    import twi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_level,
    input  line_t sda,
    output logic  start_p,
    output logic  stop_p
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= sda.fall & scl_level;
            stop_p  <= sda.rise & scl_level;
        end
    end

endmodule

// File: rtl/twi_word_rx.sv
module twi_word_rx
    import twi_pkg::*;
#(
    parameter int WORD = WORD_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_lvl,
    input  logic            start_p,
    input  logic            stop_p,
    input  logic            busy,
    output logic [WORD-1:0] word,
    output logic            word_vld,
    output logic            pull,
    output logic            wr_armed
);
    localparam int CNT_W = ctr_w(WORD + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(WORD);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(WORD + 1);

    rx_phase_e       phase;
    logic [CNT_W-1:0] bitcnt;
    logic [WORD-1:0] shreg;
    logic [WORD-1:0] nxt;
    logic            ack_en;
    logic            wrote;
    logic            shifting;

    assign nxt      = {shreg[WORD-2:0], sda_lvl};
    assign shifting = (phase == PH_CTRL) || (phase == PH_WDATA);
    assign wr_armed = (phase == PH_WDATA) && wrote;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
            pull     <= 1'b0;
            ack_en   <= 1'b0;
            wrote    <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (start_p) begin
                phase  <= busy ? PH_IDLE : PH_CTRL;
                bitcnt <= '0;
                shreg  <= '0;
                pull   <= 1'b0;
                ack_en <= 1'b0;
                wrote  <= 1'b0;
            end else if (stop_p) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                pull   <= 1'b0;
                ack_en <= 1'b0;
                wrote  <= 1'b0;
            end else if (scl_rise) begin
                if (bitcnt == ACK_SLOT) begin
                    bitcnt <= ACK_DONE;
                end else if (shifting && bitcnt < ACK_SLOT) begin
                    shreg  <= nxt;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        word     <= nxt;
                        word_vld <= 1'b1;
                        ack_en   <= 1'b1;
                        if (phase == PH_CTRL) begin
                            phase <= sda_lvl ? PH_READ : PH_WDATA;
                        end else begin
                            wrote <= 1'b1;
                        end
                    end
                end
            end else if (scl_fall) begin
                if (bitcnt == ACK_SLOT) begin
                    pull <= ack_en;
                end else if (bitcnt == ACK_DONE) begin
                    pull   <= 1'b0;
                    ack_en <= 1'b0;
                    bitcnt <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/twi_power_ctl.sv
module twi_power_ctl
    import twi_pkg::*;
#(
    parameter int WR_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_p,
    input  logic stop_p,
    input  logic wr_armed,
    output logic busy,
    output logic standby
);
    localparam int TW = ctr_w(WR_CYCLES);
    localparam logic [TW-1:0] TMR_LOAD = TW'(WR_CYCLES - 1);

    logic [TW-1:0] tmr;
    logic          bus_open;
    logic          open_nxt;

    assign open_nxt = start_p | (bus_open & ~stop_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            standby  <= 1'b1;
            tmr      <= '0;
            bus_open <= 1'b0;
        end else begin
            bus_open <= open_nxt;
            if (busy) begin
                if (tmr == '0) begin
                    busy    <= 1'b0;
                    standby <= ~open_nxt;
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end else if (stop_p && wr_armed) begin
                busy    <= 1'b1;
                standby <= 1'b0;
                tmr     <= TMR_LOAD;
            end else if (stop_p) begin
                standby <= 1'b1;
            end else if (start_p) begin
                standby <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
    import twi_pkg::*;
#(
    parameter int FILT_CYCLES = 5,
    parameter int WR_CYCLES   = 1_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic [WORD_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 start_pulse,
    output logic                 stop_pulse,
    output logic                 busy,
    output logic                 standby,
    output logic                 sda_pull
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_in;
    line_t              lines [N_LINES];
    logic               scl_lvl;
    logic               wr_armed;

    assign raw_in  = {sda_i, scl_i};
    assign scl_lvl = lines[0].level;

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        twi_glitch_filt #(
            .FILT_CYCLES(FILT_CYCLES),
            .IDLE_LEVEL (1'b1)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .raw (raw_in[g]),
            .line(lines[g])
        );
    end

    twi_bus_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .scl_level(lines[0].level),
        .sda      (lines[1]),
        .start_p  (start_pulse),
        .stop_p   (stop_pulse)
    );

    twi_word_rx #(
        .WORD(WORD_BITS)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .scl_rise(lines[0].rise),
        .scl_fall(lines[0].fall),
        .sda_lvl (lines[1].level),
        .start_p (start_pulse),
        .stop_p  (stop_pulse),
        .busy    (busy),
        .word    (rx_byte),
        .word_vld(rx_valid),
        .pull    (sda_pull),
        .wr_armed(wr_armed)
    );

    twi_power_ctl #(
        .WR_CYCLES(WR_CYCLES)
    ) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .start_p (start_pulse),
        .stop_p  (stop_pulse),
        .wr_armed(wr_armed),
        .busy    (busy),
        .standby (standby)
    );

endmodule

// File: rtl/twi_front_chk.sv
module twi_front_chk #(
    parameter int WR_CYCLES = 1_000_000
) (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic start_pulse,
    input logic stop_pulse,
    input logic busy,
    input logic standby,
    input logic sda_pull,
    input logic scl_lvl
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R2
    standby_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(standby) |-> $past(start_pulse));

    // R8
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_pulse));

    // R8
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_len == WR_CYCLES);

    // R8
    busy_standby_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && standby));

    // R10
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    // R6
    ack_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_lvl);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    standby_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> ($past(stop_pulse) || $past(busy)));

endmodule

bind twi_mem_front twi_front_chk #(
    .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .busy       (busy),
    .standby    (standby),
    .sda_pull   (sda_pull),
    .scl_lvl    (scl_lvl)
);

// File: tb/test_twi_mem_front.sv
`timescale 1ns/1ps
module test_twi_mem_front;
    localparam int FILT = 3;
    localparam int WRC  = 2000;
    localparam int Q    = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic [7:0] rx_byte;
    logic       rx_valid, start_pulse, stop_pulse, busy, standby, sda_pull;

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    int stop_cnt  = 0;
    int brun = 0;
    int last_busy = 0;
    int cyc = 0;
    logic [7:0] exp_q [$];

    assign sda_line = m_sda & ~sda_pull;

    always #5 clk = ~clk;

    twi_mem_front #(.FILT_CYCLES(FILT), .WR_CYCLES(WRC)) i_twi_mem_front (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .busy(busy), .standby(standby), .sda_pull(sda_pull)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard and tracks pulses and busy runs
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected word", int'(rx_byte), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e, "R5", "received word", int'(rx_byte), int'(e));
                end
            end
            if (start_pulse) start_cnt++;
            if (stop_pulse)  stop_cnt++;
            if (busy) brun++;
            else if (brun != 0) begin
                last_busy = brun;
                brun = 0;
            end
        end
        if (cyc == 100000) begin
            check(1'b0, "WDOG", "watchdog expired", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic bus_start();
        if (!m_scl) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(2*Q);
        end
        m_sda = 1'b0; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic bus_bit(input bit b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit exp_strobe);
        if (exp_strobe) exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(Q);
            if (i == 0) check(sda_pull == 1'b0, "R6", "pull during bit 8", int'(sda_pull), 0);
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        check(sda_pull == exp_ack, "R6", "pull before ninth clock", int'(sda_pull), int'(exp_ack));
        m_scl = 1'b1; tick(Q);
        check(sda_line == !exp_ack, "R6", "line at ninth clock", int'(sda_line), int'(!exp_ack));
        tick(Q);
        m_scl = 1'b0; tick(Q);
        check(sda_pull == 1'b0, "R6", "pull released", int'(sda_pull), 0);
    endtask

    task automatic wait_write_end();
        tick(WRC + 40);
        check(busy == 1'b0, "R8", "busy after cycle", int'(busy), 0);
        check(last_busy == WRC, "R8", "busy length", last_busy, WRC);
        check(standby == 1'b1, "R8", "standby after cycle", int'(standby), 1);
    endtask

    initial begin
        int s0;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        check(standby == 1'b1, "R1", "standby", int'(standby), 1);
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(sda_pull == 1'b0, "R1", "sda_pull", int'(sda_pull), 0);
        check(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);

        // R4 glitch shorter than the filter while clock high
        s0 = start_cnt;
        m_sda = 1'b0; tick(FILT - 1);
        m_sda = 1'b1; tick(20);
        check(start_cnt == s0, "R4", "glitch start count", start_cnt, s0);
        check(standby == 1'b1, "R4", "standby after glitch", int'(standby), 1);

        // R2 R5 R6 R8: write with two data words
        bus_start();
        check(start_cnt == s0 + 1, "R2", "start count", start_cnt, s0 + 1);
        check(standby == 1'b0, "R2", "standby after start", int'(standby), 0);
        send_byte(8'hA0, 1'b1, 1'b1);
        send_byte(8'h12, 1'b1, 1'b1);
        send_byte(8'hC5, 1'b1, 1'b1);
        s0 = stop_cnt;
        bus_stop();
        check(stop_cnt == s0 + 1, "R3", "stop count", stop_cnt, s0 + 1);
        check(busy == 1'b1, "R8", "busy after write stop", int'(busy), 1);
        check(standby == 1'b0, "R8", "standby while busy", int'(standby), 0);
        wait_write_end();

        // R10: traffic during the write cycle
        bus_start();
        send_byte(8'hA0, 1'b1, 1'b1);
        send_byte(8'h5A, 1'b1, 1'b1);
        bus_stop();
        s0 = start_cnt;
        bus_start();
        check(start_cnt == s0 + 1, "R10", "start seen while busy", start_cnt, s0 + 1);
        send_byte(8'hA0, 1'b0, 1'b0);
        bus_stop();
        check(standby == 1'b0, "R10", "standby held while busy", int'(standby), 0);
        check(busy == 1'b1, "R10", "still busy", int'(busy), 1);
        wait_write_end();

        // R7: read sequence
        last_busy = 0;
        bus_start();
        send_byte(8'hA1, 1'b1, 1'b1);
        send_byte(8'hFF, 1'b0, 1'b0);
        bus_stop();
        check(standby == 1'b1, "R7", "standby after read stop", int'(standby), 1);
        check(busy == 1'b0, "R7", "no busy after read", int'(busy), 0);
        check(last_busy == 0, "R7", "no busy run", last_busy, 0);

        // R9: write control word only
        bus_start();
        send_byte(8'hA0, 1'b1, 1'b1);
        bus_stop();
        tick(50);
        check(busy == 1'b0, "R9", "no busy without data", int'(busy), 0);
        check(standby == 1'b1, "R9", "standby after bare write", int'(standby), 1);

        // R11: start partway through a word
        bus_start();
        bus_bit(1'b1);
        bus_bit(1'b0);
        bus_bit(1'b1);
        bus_start();
        send_byte(8'hA2, 1'b1, 1'b1);
        send_byte(8'h3C, 1'b1, 1'b1);
        bus_stop();
        check(busy == 1'b1, "R11", "write after restart", int'(busy), 1);
        wait_write_end();

        check(exp_q.size() == 0, "R5", "words left unseen", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule